// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller with End-of-Interrupt Tracking

This block gathers eight level-sensitive hardware request lines and presents one interrupt output to a processor. The lines have a fixed order of importance, and the lowest-numbered line is the most important. When the processor pulses the acknowledge input, the block takes the most important eligible request and marks it as being serviced. It also registers a vector, which is a base value plus the line number. The processor can read that vector while its handler runs.

A line stays in service until software writes the end-of-interrupt command. While a line is in service, that line and every less important line are held off. Their requests stay pending as long as their inputs remain high. More important lines can still interrupt, so handlers can nest. The end-of-interrupt command retires only the most important level currently in service, so nested levels unwind one at a time.

A per-line mask silences individual lines without changing how any other line behaves. A byte-wide register port gives software four operations:
- write the mask;
- issue commands;
- read back the mask;
- read back either the pending-request set or the in-service set.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask holds 0xFF (all lines masked), the pending and in-service sets are zero, int_out is 0 and a read of the pending set returns 0.
- R2: A pending bit i is set at a clock edge while irq_in[i] is high and mask bit i is clear. int_out rises at that same edge when the request is eligible.
- R3: On an acknowledge, the eligible pending line with the lowest number wins. vec_out becomes VEC_BASE (default 0x08) plus that line number.
- R4: An acknowledged line's bit is set in the in-service set and cleared from the pending set at the acknowledge edge.
- R5: While the lowest-numbered in-service bit is N, only pending lines numbered below N can drive int_out high.
- R6: Writing 0x20 with reg_sel=0 is end-of-interrupt. It clears only the lowest-numbered set in-service bit, and higher-numbered set bits remain.
- R7: An end-of-interrupt written while the in-service set is empty changes no state.
- R8: Writing with reg_sel=1 loads the mask, and bit i masks line i. A masked line never becomes pending or raises int_out, and masking one line leaves every other line's eligibility unchanged.
- R9: rd_data shows, after each clock edge:
  - with reg_sel=1, the mask;
  - with reg_sel=0, the pending set by default or after command 0x0A;
  - with reg_sel=0, the in-service set after command 0x0B.
- R10: An acknowledge with no eligible request changes neither set and loads vec_out with VEC_BASE+7.
- R11: A request withdrawn before it is acknowledged is lost: its pending bit and int_out clear at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Level-sensitive request lines, line 0 most important |
| ack | input | 1 | One-cycle acknowledge from the processor |
| int_out | output | 1 | Registered interrupt request to the processor |
| vec_out | output | 8 | Registered vector of the last acknowledge |
| reg_sel | input | 1 | 0 selects command/status, 1 selects mask |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Register write data |
| rd_data | output | 8 | Registered read-back of the selected register |

## Verification
Several properties are checked on every cycle:
- a masked line never appears in the pending set;
- int_out is only high when a pending line ranks above every in-service line;
- an acknowledge that finds no eligible request leaves the in-service set unchanged;
- each end-of-interrupt or taken acknowledge changes the in-service population by exactly one.

Other behaviour only the bench scenarios can show:
- which line wins among several concurrent requests;
- the vector values;
- the unwinding order of nested service;
- the read-back contents;
- that a withdrawn request is lost.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned PIC_LINES = 8;
  localparam int unsigned PIC_DW    = 8;

  typedef enum logic [7:0] {
    CMD_EOI     = 8'h20,
    CMD_SEL_IRR = 8'h0A,
    CMD_SEL_ISR = 8'h0B
  } pic_cmd_e;
endpackage

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [N-1:0]  onehot,
  output logic [IW-1:0] idx
);
  logic [N:0] below;
  assign below[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign below[i+1] = below[i] | req[i];
    assign onehot[i]  = req[i] & ~below[i];
  end

  assign hit = below[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot[i]) idx = idx | IW'(i);
    end
  end
endmodule

// File: rtl/pic_level_gate.sv
module pic_level_gate #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] in_svc,
  output logic [N-1:0] allowed
);
  logic [N-1:0] upto;

  for (genvar i = 0; i < N; i++) begin : g_gate
    if (i == 0) begin : g_first
      assign upto[i] = in_svc[i];
    end else begin : g_rest
      assign upto[i] = upto[i-1] | in_svc[i];
    end
    assign allowed[i] = ~upto[i];
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned N_LINES  = PIC_LINES,
  parameter int unsigned DATA_W   = PIC_DW,
  parameter logic [7:0]  VEC_BASE = 8'h08,
  localparam int unsigned IW = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               ack,
  output logic               int_out,
  output logic [7:0]         vec_out,
  input  logic               reg_sel,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rd_data
);
  logic [N_LINES-1:0] irr_q, isr_q, mask_q;
  logic [N_LINES-1:0] irr_d, isr_d, mask_d;
  logic               sel_isr_q, sel_isr_d;

  logic [N_LINES-1:0] allow_now, allow_nxt;
  logic [N_LINES-1:0] win_oh, low_isr_oh, nxt_oh;
  logic [IW-1:0]      win_idx, low_isr_idx, nxt_idx;
  logic               win_hit, isr_hit, nxt_hit;
  logic               cmd_wr, eoi_cmd, ack_take;

  assign cmd_wr   = wr_en && !reg_sel;
  assign eoi_cmd  = cmd_wr && (wdata[7:0] == CMD_EOI);
  assign ack_take = ack && win_hit;

  pic_level_gate #(.N(N_LINES)) i_gate_now (.in_svc(isr_q), .allowed(allow_now));

  pic_prio_pick #(.N(N_LINES)) i_pick_win (
    .req(irr_q & allow_now), .hit(win_hit), .onehot(win_oh), .idx(win_idx));

  pic_prio_pick #(.N(N_LINES)) i_pick_eoi (
    .req(isr_q), .hit(isr_hit), .onehot(low_isr_oh), .idx(low_isr_idx));

  always_comb begin
    mask_d    = (wr_en && reg_sel) ? wdata[N_LINES-1:0] : mask_q;
    sel_isr_d = sel_isr_q;
    if (cmd_wr && wdata[7:0] == CMD_SEL_ISR) sel_isr_d = 1'b1;
    if (cmd_wr && wdata[7:0] == CMD_SEL_IRR) sel_isr_d = 1'b0;
    irr_d = irq_in & ~mask_d;
    if (ack_take) irr_d = irr_d & ~win_oh;
    isr_d = isr_q;
    if (eoi_cmd && isr_hit) isr_d = isr_d & ~low_isr_oh;
    if (ack_take) isr_d = isr_d | win_oh;
  end

  pic_level_gate #(.N(N_LINES)) i_gate_nxt (.in_svc(isr_d), .allowed(allow_nxt));

  pic_prio_pick #(.N(N_LINES)) i_pick_nxt (
    .req(irr_d & allow_nxt), .hit(nxt_hit), .onehot(nxt_oh), .idx(nxt_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q     <= '0;
      isr_q     <= '0;
      mask_q    <= '1;
      sel_isr_q <= 1'b0;
      int_out   <= 1'b0;
      vec_out   <= VEC_BASE;
      rd_data   <= '0;
    end else begin
      irr_q     <= irr_d;
      isr_q     <= isr_d;
      mask_q    <= mask_d;
      sel_isr_q <= sel_isr_d;
      int_out   <= nxt_hit;
      if (ack) begin
        vec_out <= VEC_BASE + (ack_take ? 8'(win_idx) : 8'(N_LINES - 1));
      end
      if (reg_sel)        rd_data <= DATA_W'(mask_d);
      else if (sel_isr_d) rd_data <= DATA_W'(isr_d);
      else                rd_data <= DATA_W'(irr_d);
    end
  end

  logic unused_ok;
  assign unused_ok = ^{nxt_oh, nxt_idx, low_isr_idx};
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         ack,
  input logic         wr_en,
  input logic         reg_sel,
  input logic [7:0]   wdata,
  input logic         int_out,
  input logic [N-1:0] irr,
  input logic [N-1:0] isr,
  input logic [N-1:0] mask
);
  function automatic int first_set(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return N;
  endfunction

  logic eoi;
  assign eoi = wr_en && !reg_sel && (wdata == 8'h20);

  assert_masked_never_pending_R8: assert property (@(posedge clk) disable iff (rst)
    (irr & mask) == '0);

  assert_int_only_above_service_R5: assert property (@(posedge clk) disable iff (rst)
    int_out |-> (first_set(irr) < first_set(isr)));

  assert_ack_takes_one_R4: assert property (@(posedge clk) disable iff (rst)
    (ack && int_out && !eoi) |=> ($countones(isr) == $countones($past(isr)) + 1));

  assert_spurious_ack_no_change_R10: assert property (@(posedge clk) disable iff (rst)
    (ack && !int_out && !eoi) |=> $stable(isr));

  assert_eoi_retires_one_R6: assert property (@(posedge clk) disable iff (rst)
    (eoi && !ack && isr != '0) |=> ($countones(isr) + 1 == $countones($past(isr))));

  assert_eoi_idle_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (eoi && !ack && isr == '0) |=> (isr == '0));
endmodule

bind prio_irq_ctrl pic_checker #(.N(N_LINES)) i_chk (
  .clk(clk), .rst(rst), .ack(ack), .wr_en(wr_en), .reg_sel(reg_sel),
  .wdata(wdata[7:0]), .int_out(int_out), .irr(irr_q), .isr(isr_q), .mask(mask_q));

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       ack = 1'b0;
  logic       reg_sel = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic       int_out;
  logic [7:0] vec_out, rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq_in), .ack(ack), .int_out(int_out),
    .vec_out(vec_out), .reg_sel(reg_sel), .wr_en(wr_en), .wdata(wdata),
    .rd_data(rd_data));

  // {mask, irq pattern, expected winning line}
  localparam logic [23:0] VECS [6] = '{
    {8'h00, 8'h80, 8'd7},
    {8'h00, 8'h81, 8'd0},
    {8'h01, 8'h81, 8'd7},
    {8'h00, 8'h30, 8'd4},
    {8'hF0, 8'h3C, 8'd2},
    {8'h00, 8'h06, 8'd1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_sel = sel; wr_en = 1'b1; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; reg_sel = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    reg_sel = sel;
    @(negedge clk);
    v = rd_data;
    reg_sel = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 int_out", int_out, 0);
    rd(1'b1, v); chk("R1 mask", v, 8'hFF);
    rd(1'b0, v); chk("R1 irr", v, 8'h00);
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R1 isr", v, 8'h00);
    wr(1'b0, 8'h0A);

    // table walk: R2, R3, R4, R8
    for (int k = 0; k < 6; k++) begin
      wr(1'b1, VECS[k][23:16]);
      irq_in = VECS[k][15:8];
      @(negedge clk);
      chk("R2 int_out raised", int_out, 1);
      do_ack();
      chk("R3 vector", vec_out, 8'h08 + VECS[k][7:0]);
      wr(1'b0, 8'h0B);
      rd(1'b0, v); chk("R4 isr bit", v, 8'h01 << VECS[k][7:0]);
      wr(1'b0, 8'h20);
      irq_in = '0;
      wr(1'b0, 8'h0A);
    end

    // R5 / R6 nesting
    wr(1'b1, 8'h00);
    irq_in = 8'h20;
    @(negedge clk);
    do_ack();
    chk("R3 line5 vector", vec_out, 8'h0D);
    irq_in = 8'hA0;
    @(negedge clk);
    chk("R5 lower line held off", int_out, 0);
    irq_in = 8'hA4;
    @(negedge clk);
    chk("R5 higher line passes", int_out, 1);
    do_ack();
    chk("R3 nested vector", vec_out, 8'h0A);
    irq_in = 8'hA0;
    wr(1'b0, 8'h0B);
    rd(1'b0, v); chk("R4 nested isr", v, 8'h24);
    chk("R5 all blocked", int_out, 0);
    wr(1'b0, 8'h20);
    rd(1'b0, v); chk("R6 eoi clears lowest only", v, 8'h20);
    chk("R5 still blocked by line5", int_out, 0);
    wr(1'b0, 8'h20);
    rd(1'b0, v); chk("R6 second eoi", v, 8'h00);
    chk("R6 int_out after unwind", int_out, 1);
    do_ack();
    chk("R3 line5 wins over 7", vec_out, 8'h0D);
    wr(1'b0, 8'h20);
    irq_in = '0;
    @(negedge clk);

    // R7 idle eoi
    wr(1'b0, 8'h20);
    rd(1'b0, v); chk("R7 isr stays empty", v, 8'h00);
    chk("R7 int_out", int_out, 0);
    wr(1'b0, 8'h0A);

    // R10 spurious acknowledge
    do_ack();
    chk("R10 vector", vec_out, 8'h0F);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); chk("R10 isr unchanged", v, 8'h00);
    wr(1'b0, 8'h0A);

    // R11 withdrawn request
    irq_in = 8'h08;
    @(negedge clk);
    chk("R11 raised", int_out, 1);
    irq_in = 8'h00;
    @(negedge clk);
    chk("R11 int_out dropped", int_out, 0);
    rd(1'b0, v); chk("R11 irr cleared", v, 8'h00);

    // R8 mask independence, R9 read-back
    wr(1'b1, 8'h08);
    irq_in = 8'h08;
    @(negedge clk);
    chk("R8 masked line silent", int_out, 0);
    irq_in = 8'h18;
    @(negedge clk);
    chk("R8 neighbour unaffected", int_out, 1);
    do_ack();
    chk("R8 neighbour vector", vec_out, 8'h0C);
    wr(1'b0, 8'h20);
    irq_in = 8'hFF;
    wr(1'b1, 8'h5A);
    rd(1'b1, v); chk("R9 mask readback", v, 8'h5A);
    rd(1'b0, v); chk("R9 irr readback", v, 8'hA5);
    irq_in = '0;
    @(negedge clk);

    finish_run();
  end
endmodule